// File: doc/BRIEF.md
# Whole-Array Erase Sequencer

This block runs a full-array erase on a flash array of 39 erase blocks. A two-write command sequence on the command port starts the run. The first write is the setup byte 30h. The next write must be the confirm byte D0h.

Once started, the sequencer walks the blocks one at a time, from index 0 (lowest address) up to index 38 (highest address). For each block it reads the lock bit through a query port. It skips any block that is protected. For each unlocked block it holds an erase strobe to the array model for a fixed, parameterised number of cycles. Main blocks take longer than the small blocks at the top.

On the last cycle of each block erase, the array returns a verify result. A failure stops the run at once. The sequencer reports its state in an 8-bit status byte and a one-cycle completion pulse. Status bits are cleared only when the next run is accepted.

Top module: `chip_erase_seq`

## Requirements
- R1: A run starts only when a write of 30h is followed directly by a write of D0h while the block is idle. A lone D0h write has no effect.
- R2: Blocks are visited in ascending index order, from 0 to 38. Each block takes one scan cycle. An unlocked block then gets ers_en_o high for MAIN_CYC cycles (indices 0..30) or SMALL_CYC cycles (indices 31..38), with ers_blk_o holding its index.
- R3: Indices 0..36 are erased when their lock bit is 0. Boot indices 37 and 38 are erased only when their lock bit is 0 and wp_i is 1.
- R4: If vfy_fail_i is high on the last erase cycle of a block, the run ends after that block. No further block is erased, and stat_o bit 5 (erase error) is set.
- R5: If no block is unlocked, nothing is erased, and the run ends with stat_o = A2h (ready, erase error, lock error in bit 1).
- R6: A confirmed start with vpp_ok_i low erases nothing and never goes busy. stat_o becomes A8h (ready, erase error, supply error in bit 3).
- R7: A setup write followed by any byte other than D0h sets stat_o bit 4 (sequence error) and bit 5. It starts no run.
- R8: A suspend command (B0h) written during a run has no effect on the erase trace.
- R9: stat_o bit 7 (ready) is 0 for the whole run. It returns to 1 in the same cycle that done_o pulses high for one cycle.
- R10: rst_ni low aborts a run at once. ers_en_o drops and stat_o reads 80h.
- R11: Any command write during a run is ignored, including a fresh 30h/D0h pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_data_i | input | 8 | Command byte |
| wp_i | input | 1 | High allows erase of the two boot blocks |
| vpp_ok_i | input | 1 | Programming supply is above lockout |
| qry_idx_o | output | 6 | Block index whose lock bit is queried |
| qry_lock_i | input | 1 | Lock bit of the queried block |
| ers_en_o | output | 1 | Erase strobe to the array |
| ers_blk_o | output | 6 | Index of the block being erased |
| vfy_fail_i | input | 1 | Verify failure, sampled on the last erase cycle |
| done_o | output | 1 | One-cycle pulse when a run ends |
| stat_o | output | 8 | Status byte: bit7 ready, bit5 erase error, bit4 sequence error, bit3 supply error, bit1 lock error |

## Verification
The bound assertions check a set of local rules on every cycle:
- the erase index is stable while the strobe is held;
- the block reads busy whenever it erases;
- the completion pulse lasts one cycle and coincides with the return to ready;
- a boot-block erase begins only with write protection released;
- the lock and supply error flags always come with the erase-error flag.

Some properties are global and only the bench scenarios can show them. These are:
- the exact ascending order;
- skipping of each locked block;
- the per-block durations;
- the early stop on a verify failure;
- the refusal of malformed, suspend and mid-run commands;
- the abort on reset.

The bench shows them by comparing the design against a trace predicted from the lock table.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_ERASE} seq_st_e;

  localparam logic [7:0] CMD_SETUP   = 8'h30;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  // status bit positions, decoded by the status register reader
  localparam int SR_RDY = 7;
  localparam int SR_ERS = 5;
  localparam int SR_SEQ = 4;
  localparam int SR_VPP = 3;
  localparam int SR_LCK = 1;
endpackage

// File: rtl/erase_cmd_dec.sv
module erase_cmd_dec
  import erase_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       we_i,
  input  logic [7:0] data_i,
  output logic       start_o,
  output logic       seq_err_o
);
  logic setup_q;
  logic wr_ok;

  assign wr_ok     = we_i && !busy_i;
  assign start_o   = wr_ok && setup_q && (data_i == CMD_CONFIRM);
  assign seq_err_o = wr_ok && setup_q && (data_i != CMD_CONFIRM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    setup_q <= 1'b0;
    else if (wr_ok) setup_q <= !setup_q && (data_i == CMD_SETUP);
  end
endmodule

// File: rtl/erase_blk_map.sv
module erase_blk_map #(
  parameter int N_MAIN    = 31,
  parameter int N_PARAM   = 6,
  parameter int N_BOOT    = 2,
  parameter int MAIN_CYC  = 12,
  parameter int SMALL_CYC = 5,
  parameter int IDXW      = 6,
  parameter int CNTW      = 4
) (
  input  logic [IDXW-1:0] idx_i,
  input  logic            lock_i,
  input  logic            wp_i,
  output logic            unlocked_o,
  output logic            last_o,
  output logic [CNTW-1:0] dur_o
);
  localparam int NBLK      = N_MAIN + N_PARAM + N_BOOT;
  localparam int BOOT_BASE = N_MAIN + N_PARAM;

  logic is_boot, is_small;

  assign is_boot    = int'(idx_i) >= BOOT_BASE;
  assign is_small   = int'(idx_i) >= N_MAIN;
  assign unlocked_o = !lock_i && (!is_boot || wp_i);
  assign last_o     = int'(idx_i) == NBLK - 1;
  assign dur_o      = is_small ? CNTW'(SMALL_CYC - 1) : CNTW'(MAIN_CYC - 1);
endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
  parameter int CNTW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [CNTW-1:0] load_val_i,
  output logic            expired_o
);
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq
  import erase_seq_pkg::*;
#(
  parameter int N_MAIN    = 31,
  parameter int N_PARAM   = 6,
  parameter int N_BOOT    = 2,
  parameter int MAIN_CYC  = 12,
  parameter int SMALL_CYC = 5,
  localparam int NBLK     = N_MAIN + N_PARAM + N_BOOT,
  localparam int IDXW     = $clog2(NBLK),
  localparam int CNTW     = $clog2(MAIN_CYC + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_we_i,
  input  logic [7:0]      cmd_data_i,
  input  logic            wp_i,
  input  logic            vpp_ok_i,
  output logic [IDXW-1:0] qry_idx_o,
  input  logic            qry_lock_i,
  output logic            ers_en_o,
  output logic [IDXW-1:0] ers_blk_o,
  input  logic            vfy_fail_i,
  output logic            done_o,
  output logic [7:0]      stat_o
);
  seq_st_e         st_q;
  logic [IDXW-1:0] idx_q;
  logic            any_q, done_q;
  logic            ers_err_q, seq_err_q, vpp_err_q, lck_err_q;
  logic            busy, start, seq_err;
  logic            unlocked, is_last, tmr_load, tmr_exp;
  logic [CNTW-1:0] dur;

  assign busy = (st_q != ST_IDLE);

  erase_cmd_dec u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy),
    .we_i      (cmd_we_i),
    .data_i    (cmd_data_i),
    .start_o   (start),
    .seq_err_o (seq_err)
  );

  erase_blk_map #(
    .N_MAIN(N_MAIN), .N_PARAM(N_PARAM), .N_BOOT(N_BOOT),
    .MAIN_CYC(MAIN_CYC), .SMALL_CYC(SMALL_CYC), .IDXW(IDXW), .CNTW(CNTW)
  ) u_map (
    .idx_i      (idx_q),
    .lock_i     (qry_lock_i),
    .wp_i       (wp_i),
    .unlocked_o (unlocked),
    .last_o     (is_last),
    .dur_o      (dur)
  );

  assign tmr_load = (st_q == ST_SCAN) && unlocked;

  erase_timer #(.CNTW(CNTW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (dur),
    .expired_o  (tmr_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      any_q     <= 1'b0;
      done_q    <= 1'b0;
      ers_err_q <= 1'b0;
      seq_err_q <= 1'b0;
      vpp_err_q <= 1'b0;
      lck_err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            seq_err_q <= 1'b0;
            lck_err_q <= 1'b0;
            ers_err_q <= !vpp_ok_i;
            vpp_err_q <= !vpp_ok_i;
            if (vpp_ok_i) begin
              st_q  <= ST_SCAN;
              idx_q <= '0;
              any_q <= 1'b0;
            end
          end else if (seq_err) begin
            seq_err_q <= 1'b1;
            ers_err_q <= 1'b1;
          end
        end
        ST_SCAN: begin
          if (unlocked) begin
            st_q  <= ST_ERASE;
            any_q <= 1'b1;
          end else if (is_last) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            if (!any_q) begin
              lck_err_q <= 1'b1;
              ers_err_q <= 1'b1;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_ERASE: begin
          if (tmr_exp) begin
            if (vfy_fail_i || is_last) begin
              st_q      <= ST_IDLE;
              done_q    <= 1'b1;
              ers_err_q <= ers_err_q | vfy_fail_i;
            end else begin
              st_q  <= ST_SCAN;
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign qry_idx_o = idx_q;
  assign ers_blk_o = idx_q;
  assign ers_en_o  = (st_q == ST_ERASE);
  assign done_o    = done_q;

  always_comb begin
    stat_o         = '0;
    stat_o[SR_RDY] = !busy;
    stat_o[SR_ERS] = ers_err_q;
    stat_o[SR_SEQ] = seq_err_q;
    stat_o[SR_VPP] = vpp_err_q;
    stat_o[SR_LCK] = lck_err_q;
  end
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
  parameter int BOOT_BASE = 37,
  parameter int IDXW      = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wp_i,
  input logic            ers_en_o,
  input logic [IDXW-1:0] ers_blk_o,
  input logic            done_o,
  input logic [7:0]      stat_o
);
  // R2
  blk_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ers_en_o && $past(ers_en_o) |-> ers_blk_o == $past(ers_blk_o));

  // R9
  busy_while_erase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ers_en_o |-> !stat_o[7]);

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> stat_o[7] && !$past(stat_o[7]));

  // R3
  boot_wp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ers_en_o) && int'(ers_blk_o) >= BOOT_BASE |-> $past(wp_i));

  // R5
  lock_err_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[1] |-> stat_o[5]);

  // R6
  vpp_err_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[3] |-> stat_o[5] && !ers_en_o);
endmodule

bind chip_erase_seq erase_seq_chk #(
  .BOOT_BASE(N_MAIN + N_PARAM),
  .IDXW     (IDXW)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wp_i     (wp_i),
  .ers_en_o (ers_en_o),
  .ers_blk_o(ers_blk_o),
  .done_o   (done_o),
  .stat_o   (stat_o)
);

// File: tb/chip_erase_seq_tb_top.sv
`timescale 1ns/1ps
module chip_erase_seq_tb_top;
  localparam int NB = 39;
  localparam int NMAIN = 31;
  localparam int BOOTB = 37;
  localparam int MCYC = 12;
  localparam int SCYC = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic       wp = 1'b1;
  logic       vpp_ok = 1'b1;
  logic [5:0] qry_idx;
  logic       qry_lock;
  logic       ers_en;
  logic [5:0] ers_blk;
  logic       vfy_fail;
  logic       done;
  logic [7:0] stat;

  bit lk [0:63];
  int fail_blk = -1;
  int n_cmp = 0;
  int n_bad = 0;

  int q_en[$], q_blk[$], q_busy[$], q_done[$];

  always #2 clk = ~clk;

  assign qry_lock = lk[qry_idx];
  assign vfy_fail = ers_en && (int'(ers_blk) == fail_blk);

  chip_erase_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_data_i(cmd),
    .wp_i(wp), .vpp_ok_i(vpp_ok), .qry_idx_o(qry_idx), .qry_lock_i(qry_lock),
    .ers_en_o(ers_en), .ers_blk_o(ers_blk), .vfy_fail_i(vfy_fail),
    .done_o(done), .stat_o(stat)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit blk_open(input int b);
    return !lk[b] && (b < BOOTB || wp);
  endfunction

  // predicted trace of one run (R2, R3, R4, R5)
  task automatic plan_run();
    for (int b = 0; b < NB; b++) begin
      q_en.push_back(0); q_blk.push_back(0); q_busy.push_back(1); q_done.push_back(0);
      if (blk_open(b)) begin
        for (int d = 0; d < ((b < NMAIN) ? MCYC : SCYC); d++) begin
          q_en.push_back(1); q_blk.push_back(b); q_busy.push_back(1); q_done.push_back(0);
        end
        if (b == fail_blk) break;
      end
    end
    q_en.push_back(0); q_blk.push_back(0); q_busy.push_back(0); q_done.push_back(1);
  endtask

  // per-cycle comparison against the trace
  always @(negedge clk) begin
    if (rst_n) begin
      int e_en, e_blk, e_busy, e_done;
      if (q_en.size() > 0) begin
        e_en = q_en.pop_front(); e_blk = q_blk.pop_front();
        e_busy = q_busy.pop_front(); e_done = q_done.pop_front();
      end else begin
        e_en = 0; e_blk = 0; e_busy = 0; e_done = 0;
      end
      chk(ers_en == e_en[0] && (!e_en[0] || int'(ers_blk) == e_blk),
          "R2 erase trace", {ers_en, 2'b0, ers_blk}, {e_en[0], 2'b0, e_blk[5:0]});
      chk(!stat[7] == e_busy[0], "R9 busy", !stat[7], e_busy);
      chk(done == e_done[0], "R9 done pulse", done, e_done);
    end
  end

  task automatic write_cmd(input logic [7:0] d, input bit launch);
    @(negedge clk);
    cmd_we = 1'b1; cmd = d;
    @(posedge clk); #1;
    if (launch) plan_run();
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (q_en.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [7:0] exp_stat, input string tag);
    write_cmd(8'h30, 0);
    write_cmd(8'hD0, 1);
    wait_idle();
    chk(stat == exp_stat, tag, stat, exp_stat);
  endtask

  task automatic set_locks(input bit v);
    for (int i = 0; i < 64; i++) lk[i] = v;
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    set_locks(0);
    repeat (3) @(negedge clk);
    chk(stat == 8'h80 && !ers_en, "R10 reset state", stat, 8'h80);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3: everything open
    run(8'h80, "R2 full run status");

    // R7: wrong confirm byte
    write_cmd(8'h30, 0);
    write_cmd(8'h40, 0);
    repeat (2) @(negedge clk);
    chk(stat == 8'hB0, "R7 bad confirm", stat, 8'hB0);

    // R1: lone confirm does nothing
    write_cmd(8'hD0, 0);
    repeat (3) @(negedge clk);
    chk(stat == 8'hB0 && !ers_en, "R1 lone confirm", stat, 8'hB0);

    // R3: mixed locks, boot protected by wp low
    for (int i = 0; i < NB; i++) lk[i] = (i % 3 == 1);
    lk[37] = 0; lk[38] = 0; wp = 0;
    run(8'h80, "R3 mixed locks status");

    // R4: verify failure stops the run
    set_locks(0); wp = 1; lk[2] = 1; fail_blk = 5;
    run(8'hA0, "R4 fail status");
    fail_blk = -1;

    // R5: everything locked
    set_locks(1);
    run(8'hA2, "R5 all locked");

    // R3 R5: only boot bits clear, wp low
    lk[37] = 0; lk[38] = 0; wp = 0;
    run(8'hA2, "R3 boot held by wp");

    // R6: supply below lockout
    set_locks(0); wp = 1; vpp_ok = 0;
    write_cmd(8'h30, 0);
    write_cmd(8'hD0, 0);
    repeat (3) @(negedge clk);
    chk(stat == 8'hA8 && !ers_en, "R6 supply low", stat, 8'hA8);
    vpp_ok = 1;

    // R8 R11: suspend and commands during a run are ignored
    for (int i = 0; i < NB; i++) lk[i] = (i >= 20 && i < 30);
    write_cmd(8'h30, 0);
    write_cmd(8'hD0, 1);
    repeat (20) @(negedge clk);
    write_cmd(8'hB0, 0);
    write_cmd(8'h30, 0);
    write_cmd(8'hD0, 0);
    write_cmd(8'h40, 0);
    wait_idle();
    chk(stat == 8'h80, "R8 R11 ignored writes status", stat, 8'h80);

    // R10: reset mid-run
    set_locks(0);
    write_cmd(8'h30, 0);
    write_cmd(8'hD0, 1);
    repeat (100) @(negedge clk);
    #1;
    rst_n = 1'b0;
    q_en.delete(); q_blk.delete(); q_busy.delete(); q_done.delete();
    #1;
    chk(!ers_en && stat == 8'h80, "R10 abort on reset", {ers_en, stat}, 8'h80);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!ers_en && stat == 8'h80, "R10 stays idle", {ers_en, stat}, 8'h80);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule